// File: doc/BRIEF.md
# Stereo pixel feature encoder

This block turns a raster stream of 24-bit colour pixels into a stream of 12-bit per-pixel descriptors for a stereo matcher. Each accepted pixel is reduced to 8-bit luminance and stored in a small ring of line stores. A 7x7 luminance neighbourhood slides over the image one column per accepted pixel, and for every window centre the block emits one packed word. The word carries a coarse intensity segment label, a six-bit sparse census signature, and a two-bit code that tells the matcher which support-window size (7x7, 13x13 or 25x25) suits the local texture. The code is picked by comparing the summed absolute deviation of the neighbourhood against two programmable thresholds.

The frame geometry is fixed by parameters. The frame position is implied by the number of pixels accepted since reset, and frames follow each other with no separator. Neighbours that fall outside the image take the value of the nearest edge pixel. The pipeline advances only when a pixel is accepted. The descriptor of pixel n therefore leaves the block after pixel n+3W+3 has been accepted, and the last 3W+3 descriptors of a stream are pushed out by the pixels that follow.

Top module: `stereo_feat_enc`

## Requirements
- R1: Luminance is Y = (77*R + 150*G + 29*B) >> 8 on unsigned 8-bit channels, with R in pix_rgb[23:16], G in [15:8] and B in [7:0]; all descriptor fields are functions of Y only.
- R2: feat_word[11:8] is the centre luminance shifted right by 4 (16 intensity segments).
- R3: feat_word[7:2] is the census signature. Its bits, from bit 7 down to bit 2, compare the centre with the neighbours at (row,col) offsets (-2,-2), (-2,0), (-2,+2), (+2,-2), (+2,0), (+2,+2). A bit is 0 when that neighbour is brighter than the centre and 1 otherwise.
- R4: Let S be the sum of |Y(q) - Y(c)| over the 7x7 window. feat_word[1:0] is 00 (7x7) when S > 48*th_tex_hi, 01 (13x13) when S > 48*th_tex_lo and S <= 48*th_tex_hi, and 10 (25x25) otherwise. Equality falls to the larger window, and 11 never appears.
- R5: Window rows above row 0 or below row H-1 take the luminance of row 0 or row H-1 in the same column.
- R6: Window columns left of column 0 or right of column W-1 take the luminance of column 0 or column W-1 in the same row.
- R7: Descriptors leave in raster order. The descriptor of pixel n is presented with feat_valid high for one cycle, two clock edges after the edge that accepts pixel n+3W+3.
- R8: A cycle with pix_valid low does not advance the pipeline. feat_valid stays low in any cycle not named by R7, and descriptors are unaffected by the gaps.
- R9: While reset is asserted feat_valid is low, and the first 3W+3 pixels accepted after reset produce no descriptor.
- R10: Frames follow back to back. Pixel W*H after reset is row 0, column 0 of the next frame, and windows never mix rows of two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_valid | input | 1 | An input pixel is present this cycle |
| pix_rgb | input | 24 | Pixel colour, R[23:16] G[15:8] B[7:0] |
| th_tex_hi | input | 8 | Deviation threshold above which the 7x7 window is chosen |
| th_tex_lo | input | 8 | Deviation threshold above which the 13x13 window is chosen |
| feat_valid | output | 1 | feat_word holds a descriptor |
| feat_word | output | 12 | {segment[3:0], census[5:0], window code[1:0]} |

## Verification
The hardest situation to reach is a mean deviation exactly equal to a threshold, and it must coincide with a window clamped at an image edge. Random images almost never produce it. The stimulus builds flat gray frames with one raised pixel, so the deviation sum comes to exactly 48, 96 or 144. With thresholds of 1 and 2 this lands on both equality boundaries and on the strict case. These frames run back to back, so windows near the bottom rows are formed while the next frame is already being written. A second run inserts pseudo-random idle cycles between pixels, which checks that stalls neither shift the raster position nor break the two-edge output timing.

// File: rtl/stereo_feat_pkg.sv
package stereo_feat_pkg;

  localparam int unsigned LUMA_W = 8;
  localparam int unsigned WIN    = 7;
  localparam int unsigned HALF   = WIN / 2;
  localparam int unsigned NCENS  = 6;
  localparam int unsigned NPEER  = WIN * WIN - 1;

  typedef logic [LUMA_W-1:0] luma_t;

  typedef enum logic [1:0] {
    WSZ_SMALL = 2'b00,
    WSZ_MID   = 2'b01,
    WSZ_LARGE = 2'b10
  } wsz_code_e;

  typedef struct packed {
    logic [3:0]       seg;
    logic [NCENS-1:0] census;
    wsz_code_e        wsz;
  } feat_word_t;

endpackage

// File: rtl/sfe_luma.sv
module sfe_luma
  import stereo_feat_pkg::*;
(
  input  logic [23:0] rgb_i,
  output luma_t       y_o
);

  localparam logic [15:0] KR = 16'd77;
  localparam logic [15:0] KG = 16'd150;
  localparam logic [15:0] KB = 16'd29;

  logic [15:0] acc;

  always_comb begin
    acc = 16'(rgb_i[23:16]) * KR
        + 16'(rgb_i[15:8])  * KG
        + 16'(rgb_i[7:0])   * KB;
    y_o = acc[15:8];
  end

endmodule

// File: rtl/sfe_line_store.sv
module sfe_line_store
  import stereo_feat_pkg::*;
#(
  parameter int unsigned IMG_W = 64,
  parameter int unsigned IMG_H = 48
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv_i,
  input  luma_t y_i,
  output luma_t col_o [WIN]
);

  localparam int unsigned NSLOT = 8;
  localparam int unsigned SLW   = $clog2(NSLOT);
  localparam int unsigned CW    = (IMG_W > 1) ? $clog2(IMG_W) : 1;
  localparam int unsigned RW    = (IMG_H > 1) ? $clog2(IMG_H) : 1;

  luma_t          mem [NSLOT][IMG_W];
  logic [CW-1:0]  wcol, wcol_nx;
  logic [SLW-1:0] wslot, wslot_nx;
  logic [RW-1:0]  rrow, rrow_nx;

  logic [SLW-1:0] rd_slot [WIN];
  logic           rd_byp  [WIN];

  // write position and the row whose 7-row set is read this cycle
  always_comb begin
    wcol_nx  = wcol;
    wslot_nx = wslot;
    rrow_nx  = rrow;
    if (adv_i) begin
      if (wcol == CW'(IMG_W - 1)) begin
        wcol_nx  = '0;
        wslot_nx = wslot + SLW'(1);
        rrow_nx  = (rrow == RW'(IMG_H - 1)) ? '0 : rrow + RW'(1);
      end else begin
        wcol_nx = wcol + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcol  <= '0;
      wslot <= '0;
      rrow  <= RW'(IMG_H - HALF);
    end else if (adv_i) begin
      wcol  <= wcol_nx;
      wslot <= wslot_nx;
      rrow  <= rrow_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (adv_i) begin
      mem[wslot][wcol] <= y_i;
    end
  end

  // vertical clamp: row offset is limited to the frame, newest row bypasses
  always_comb begin
    int tr;
    int dl;
    for (int d = 0; d < int'(WIN); d++) begin
      tr = int'(rrow) + d - int'(HALF);
      if (tr < 0)            tr = 0;
      if (tr > int'(IMG_H) - 1) tr = int'(IMG_H) - 1;
      dl = tr - int'(rrow);
      rd_byp[d]  = (dl == int'(HALF));
      rd_slot[d] = wslot + SLW'(dl + int'(NSLOT) - int'(HALF));
      col_o[d]   = rd_byp[d] ? y_i : mem[rd_slot[d]][wcol];
    end
  end

  for (genvar g = 0; g < int'(WIN); g++) begin : g_chk
    // R5, R10: a stored row read for the window is never the row being written
    a_r5_slot_apart: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !rd_byp[g]) |-> (rd_slot[g] != wslot));
  end

endmodule

// File: rtl/sfe_window.sv
module sfe_window
  import stereo_feat_pkg::*;
#(
  parameter int unsigned IMG_W = 64,
  parameter int unsigned IMG_H = 48
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv_i,
  input  luma_t col_i [WIN],
  output luma_t win_o [WIN][WIN],
  output logic  fresh_o
);

  localparam int unsigned DLY = HALF * IMG_W + HALF;
  localparam int unsigned FW  = $clog2(DLY + 2);
  localparam int unsigned CW  = (IMG_W > 1) ? $clog2(IMG_W) : 1;
  localparam int unsigned RW  = (IMG_H > 1) ? $clog2(IMG_H) : 1;
  localparam int unsigned IW  = $clog2(WIN);

  luma_t         cols [WIN][WIN];
  logic [CW-1:0] ccol, ccol_nx;
  logic [RW-1:0] crow, crow_nx;
  logic [FW-1:0] fill, fill_nx;
  logic          adv_q;

  // centre position of the registered window and fill level
  always_comb begin
    ccol_nx = ccol;
    crow_nx = crow;
    fill_nx = fill;
    if (adv_i) begin
      if (ccol == CW'(IMG_W - 1)) begin
        ccol_nx = '0;
        crow_nx = (crow == RW'(IMG_H - 1)) ? '0 : crow + RW'(1);
      end else begin
        ccol_nx = ccol + CW'(1);
      end
      if (fill != FW'(DLY + 1)) fill_nx = fill + FW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccol  <= CW'(IMG_W - 4);
      crow  <= RW'(IMG_H - 4);
      fill  <= '0;
      adv_q <= 1'b0;
    end else begin
      adv_q <= adv_i;
      if (adv_i) begin
        ccol <= ccol_nx;
        crow <= crow_nx;
        fill <= fill_nx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (adv_i) begin
      cols[0] <= col_i;
      for (int j = 1; j < int'(WIN); j++) cols[j] <= cols[j-1];
    end
  end

  // horizontal clamp: columns outside the frame take the edge column slot
  always_comb begin
    int c;
    int src;
    for (int k = 0; k < int'(WIN); k++) begin
      c   = int'(ccol) - int'(HALF) + k;
      src = k;
      if (c < 0)                 src = int'(HALF) - int'(ccol);
      else if (c > int'(IMG_W) - 1) src = int'(IMG_W) - 1 + int'(HALF) - int'(ccol);
      for (int r = 0; r < int'(WIN); r++) begin
        win_o[r][k] = cols[IW'(int'(WIN) - 1 - src)][r];
      end
    end
  end

  assign fresh_o = adv_q && (fill == FW'(DLY + 1));

  // R6: at the left and right image edges the outer columns repeat the edge
  a_r6_left_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (fresh_o && ccol == '0) |-> (win_o[HALF][0] == win_o[HALF][HALF]));
  a_r6_right_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (fresh_o && ccol == CW'(IMG_W - 1)) |-> (win_o[HALF][WIN-1] == win_o[HALF][HALF]));

endmodule

// File: rtl/sfe_descriptor.sv
module sfe_descriptor
  import stereo_feat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take_i,
  input  luma_t      win_i [WIN][WIN],
  input  logic [7:0] th_hi_i,
  input  logic [7:0] th_lo_i,
  output feat_word_t word_o,
  output logic       valid_o
);

  localparam int unsigned SUMW = $clog2(NPEER * 255 + 1);
  localparam int NB_DR [NCENS] = '{-2, -2, -2, 2, 2, 2};
  localparam int NB_DC [NCENS] = '{-2,  0,  2, -2, 0, 2};

  luma_t            ctr;
  logic [SUMW-1:0]  sad;
  logic [SUMW-1:0]  lim_hi, lim_lo;
  feat_word_t       word_nx;
  luma_t            dev;

  always_comb begin
    ctr = win_i[HALF][HALF];
    sad = '0;
    for (int r = 0; r < int'(WIN); r++) begin
      for (int k = 0; k < int'(WIN); k++) begin
        dev = (win_i[r][k] > ctr) ? (win_i[r][k] - ctr) : (ctr - win_i[r][k]);
        sad = sad + SUMW'(dev);
      end
    end
    lim_hi = SUMW'(th_hi_i) * SUMW'(NPEER);
    lim_lo = SUMW'(th_lo_i) * SUMW'(NPEER);

    word_nx.seg = ctr[7:4];
    for (int n = 0; n < int'(NCENS); n++) begin
      word_nx.census[NCENS-1-n] =
        !(win_i[int'(HALF) + NB_DR[n]][int'(HALF) + NB_DC[n]] > ctr);
    end
    if (sad > lim_hi)      word_nx.wsz = WSZ_SMALL;
    else if (sad > lim_lo) word_nx.wsz = WSZ_MID;
    else                   word_nx.wsz = WSZ_LARGE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      word_o  <= '0;
    end else begin
      valid_o <= take_i;
      if (take_i) word_o <= word_nx;
    end
  end

  // R4: the reserved window code never leaves the block
  a_r4_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (word_o.wsz != 2'b11));

endmodule

// File: rtl/stereo_feat_enc.sv
module stereo_feat_enc
  import stereo_feat_pkg::*;
#(
  parameter int unsigned IMG_W = 64,
  parameter int unsigned IMG_H = 48
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pix_valid,
  input  logic [23:0] pix_rgb,
  input  logic [7:0]  th_tex_hi,
  input  logic [7:0]  th_tex_lo,
  output logic        feat_valid,
  output logic [11:0] feat_word
);

  localparam int unsigned DLY = HALF * IMG_W + HALF;
  localparam int unsigned KW  = $clog2(DLY + 2);

  logic       rst_meta, rst_sync_n;
  luma_t      y;
  luma_t      col [WIN];
  luma_t      win [WIN][WIN];
  logic       fresh;
  feat_word_t word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  sfe_luma u_luma (
    .rgb_i (pix_rgb),
    .y_o   (y)
  );

  sfe_line_store #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_lines (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .adv_i (pix_valid),
    .y_i   (y),
    .col_o (col)
  );

  sfe_window #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_win (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .adv_i   (pix_valid),
    .col_i   (col),
    .win_o   (win),
    .fresh_o (fresh)
  );

  sfe_descriptor u_desc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .take_i  (fresh),
    .win_i   (win),
    .th_hi_i (th_tex_hi),
    .th_lo_i (th_tex_lo),
    .word_o  (word),
    .valid_o (feat_valid)
  );

  assign feat_word = word;

  // independent count of accepted pixels for the priming check
  logic [KW-1:0] chk_cnt;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) chk_cnt <= '0;
    else if (pix_valid && chk_cnt != KW'(DLY + 1)) chk_cnt <= chk_cnt + KW'(1);
  end

  // R9: no descriptor before 3W+3 pixels have been accepted
  a_r9_primed: assert property (@(posedge clk) disable iff (!rst_sync_n)
    feat_valid |-> (chk_cnt == KW'(DLY + 1)));
  // R7, R8: every descriptor is caused by a pixel accepted two edges earlier
  a_r7_after_input: assert property (@(posedge clk) disable iff (!rst_sync_n)
    feat_valid |-> $past(pix_valid, 2));

endmodule

// File: tb/stereo_feat_enc_tb.sv
module stereo_feat_enc_tb;

  localparam int W    = 8;
  localparam int H    = 6;
  localparam int WH   = W * H;
  localparam int D    = 3 * W + 3;
  localparam int MAXN = 320;
  localparam int WDOG = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pix_valid;
  logic [23:0] pix_rgb;
  logic [7:0]  th_tex_hi, th_tex_lo;
  logic        feat_valid;
  logic [11:0] feat_word;

  always #2 clk = ~clk;

  stereo_feat_enc #(.IMG_W(W), .IMG_H(H)) u_dut (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_rgb(pix_rgb),
    .th_tex_hi(th_tex_hi), .th_tex_lo(th_tex_lo),
    .feat_valid(feat_valid), .feat_word(feat_word)
  );

  int yst  [MAXN];
  int dcyc [MAXN];
  int nacc, nout, cyc, checks, errors;
  int unsigned seed;
  bit done;

  function automatic int unsigned nxt_rand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic int luma_of(logic [23:0] p);
    return (77 * int'(p[23:16]) + 150 * int'(p[15:8]) + 29 * int'(p[7:0])) >> 8;
  endfunction

  function automatic int yat(int f, int r, int c);
    int rr = (r < 0) ? 0 : ((r > H - 1) ? H - 1 : r);
    int cc = (c < 0) ? 0 : ((c > W - 1) ? W - 1 : c);
    return yst[f * WH + rr * W + cc];
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic monitor();
    if (feat_valid) begin
      int n = nout;
      int f = n / WH;
      int p = n % WH;
      int r = p / W;
      int c = p % W;
      int yc, cen, sum, code, ed;
      string tg;
      // R7 R8: order and two-edge timing relative to pixel n+3W+3
      ed = (n + D < nacc) ? dcyc[n + D] + 2 : -1;
      check(ed == cyc, "R7 R8 output timing", cyc, ed);
      yc  = yat(f, r, c);
      cen = 0;
      for (int k = 0; k < 6; k++) begin
        int dr = (k < 3) ? -2 : 2;
        int dc = (k % 3) * 2 - 2;
        cen = (cen << 1) | ((yat(f, r + dr, c + dc) > yc) ? 0 : 1);
      end
      sum = 0;
      for (int dr = -3; dr <= 3; dr++)
        for (int dc = -3; dc <= 3; dc++) begin
          int v = yat(f, r + dr, c + dc);
          sum += (v > yc) ? v - yc : yc - v;
        end
      code = (sum > 48 * int'(th_tex_hi)) ? 0 : ((sum > 48 * int'(th_tex_lo)) ? 1 : 2);
      tg = "R1";
      if (r < 3 || r > H - 4) tg = {tg, " R5"};
      if (c < 3 || c > W - 4) tg = {tg, " R6"};
      if (f > 0)              tg = {tg, " R10"};
      check(int'(feat_word[11:8]) == (yc >> 4), {"R2 segment ", tg}, int'(feat_word[11:8]), yc >> 4);
      check(int'(feat_word[7:2]) == cen, {"R3 census ", tg}, int'(feat_word[7:2]), cen);
      check(int'(feat_word[1:0]) == code, {"R4 window code ", tg}, int'(feat_word[1:0]), code);
      nout++;
    end else if (nout + D < nacc && dcyc[nout + D] + 2 == cyc) begin
      check(1'b0, "R7 R8 missing descriptor", 0, 1);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    monitor();
  endtask

  task automatic idle();
    step();
    pix_valid = 1'b0;
  endtask

  task automatic push(logic [23:0] p);
    step();
    pix_valid = 1'b1;
    pix_rgb   = p;
    yst[nacc]  = luma_of(p);
    dcyc[nacc] = cyc;
    nacc++;
  endtask

  // kinds: 0 random colour, 1 gray ramp, 2..4 flat 10 with one raised pixel, 5 stripes
  function automatic logic [23:0] gen(int kind, int r, int c);
    logic [7:0] v;
    case (kind)
      0: return 24'(nxt_rand());
      1: v = 8'(r * 40 + c * 9);
      2: v = (r == 3 && c == 4) ? 8'd11 : 8'd10;
      3: v = (r == 3 && c == 4) ? 8'd12 : 8'd10;
      4: v = (r == 3 && c == 4) ? 8'd13 : 8'd10;
      default: v = (c % 2 == 1) ? 8'd200 : 8'd30;
    endcase
    return {v, v, v};
  endfunction

  task automatic frame(int kind, bit gaps);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        if (gaps) while (nxt_rand() % 3 == 0) idle();
        push(gen(kind, r, c));
      end
  endtask

  task automatic do_reset();
    step();
    rst_n     = 1'b0;
    pix_valid = 1'b0;
    nacc = 0;
    nout = 0;
    for (int i = 0; i < 3; i++) begin
      step();
      check(feat_valid == 1'b0, "R9 reset output", int'(feat_valid), 0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) idle();
  endtask

  task automatic finish_run();
    for (int i = 0; i < 4; i++) idle();
    // R9: the last 3W+3 descriptors stay inside until more pixels arrive
    check(nout == nacc - D, "R9 descriptor count", nout, nacc - D);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    seed = 32'h1234_5679;
    rst_n = 1'b0;
    pix_valid = 1'b0;
    pix_rgb = '0;
    checks = 0; errors = 0; cyc = 0; done = 1'b0;
    th_tex_hi = 8'd20;
    th_tex_lo = 8'd6;
    do_reset();
    // run 1: stalls between pixels, mixed content
    frame(0, 1'b1);
    frame(1, 1'b1);
    frame(5, 1'b1);
    frame(0, 1'b1);
    finish_run();
    // run 2: continuous stream, deviation sums 48/96/144 against limits 48/96
    th_tex_hi = 8'd2;
    th_tex_lo = 8'd1;
    do_reset();
    frame(2, 1'b0);
    frame(3, 1'b0);
    frame(4, 1'b0);
    frame(0, 1'b0);
    frame(0, 1'b0);
    finish_run();
    summary();
  end

  initial begin
    forever begin
      @(negedge clk);
      if (cyc > WDOG && !done) begin
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, WDOG);
        summary();
      end
    end
  end

endmodule